// File: doc/BRIEF.md
# Broadcast Frame Receiver with Checksum

This block sits on a slave node of a converter control network. A UART receiver, outside the block, turns the serial line into bytes, and the block takes those bytes one at a time. It waits for a start marker and then reads a length byte. It collects the number of data bytes that the length gives, then a checksum byte. The master sends one frame that every slave receives at the same time. The frame carries no slave address. Instead, the data bytes are grouped into fixed-size records, and the first byte of each record is a module number. The block keeps only the records whose module number equals its own node ID.

Records that match are held in a small staging store. They are released only after the checksum proves the frame good. When that happens, the block raises a one-cycle frame-good pulse and then streams the stored records out, one per cycle. The local control logic therefore never acts on data from a corrupted frame. A frame that fails raises a one-cycle error pulse with a cause code, and its staged records are thrown away. If the line goes quiet in the middle of a frame for a set number of bit-times, the block abandons the frame and hunts for the next start marker.

Top module: `frame_rx_top`

## Requirements
- R1: After reset, `busy`, `frame_ok`, `frame_err` and `rec_valid` are all low.
- R2: While no frame is open, every byte other than the start marker (default 0xA5) is ignored: `busy` stays low and no pulse or record comes out.
- R3: A start marker opens a frame, so `busy` is high after that byte. The next byte is the length, counted in data bytes.
- R4: A length above MAX_LEN (default 64), or a length that is not a whole multiple of REC_BYTES (default 3), ends the frame at once with `frame_err` and `err_code` = 2.
- R5: The frame is good when the 8-bit sum of the length byte, every data byte and the checksum byte is zero. A good frame gives a `frame_ok` pulse in the cycle after the checksum byte. Otherwise the block gives a `frame_err` pulse with `err_code` = 1.
- R6: Each record is REC_BYTES bytes long: first the module number, then the payload, with the first payload byte in the most significant position of `rec_payload`. After a good frame, the matching records appear on `rec_payload` with `rec_valid` high. They come in arrival order, one per cycle, with no gaps, and the first one appears in the same cycle as `frame_ok`.
- R7: A record whose module number differs from `node_id` is never delivered. A frame that fails delivers none of its records.
- R8: If no byte arrives for TIMEOUT_BITS x CLKS_PER_BIT cycles (default 32 x 34) while a frame is open, `frame_err` pulses with `err_code` = 3 in the cycle after the last idle cycle, and `busy` drops.
- R9: A length of zero is legal. The checksum byte follows the length directly, and a good frame gives `frame_ok` with no records.
- R10: A byte equal to the start marker inside the length, data or checksum field counts as ordinary data.
- R11: `frame_ok` and `frame_err` are one-cycle pulses, never high together, and one of them marks every cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | One-cycle strobe, `rx_byte` is valid |
| node_id | input | 8 | Module number of this node |
| busy | output | 1 | A frame is open |
| frame_ok | output | 1 | Pulse: frame passed its checksum |
| frame_err | output | 1 | Pulse: frame rejected |
| err_code | output | 2 | Cause of the last rejection: 1 checksum, 2 length, 3 timeout |
| rec_valid | output | 1 | `rec_payload` holds a delivered record |
| rec_payload | output | (REC_BYTES-1)*8 | Payload of a matching record |

## Verification
If the block mistracks its position in a frame, the checksum of the very next frame fails. The bench then sees `frame_err` with cause 1 in the cycle after that frame's last byte, in place of the expected `frame_ok`. A staging store that keeps stale entries, or that loses entries, shows up in the scoreboard as extra, missing or reordered records within a few cycles of `frame_ok`. A wrong idle counter moves the timeout pulse away from the exact cycle the bench predicts. Filtering and length errors show on `busy` and the pulse outputs at the byte that should trigger them.

// File: rtl/frx_pkg.sv
package frx_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_LEN  = 2'd1,
      ST_DATA = 2'd2,
      ST_CHK  = 2'd3
   } frx_state_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_SUM     = 2'd1,
      ERR_LEN     = 2'd2,
      ERR_TIMEOUT = 2'd3
   } frx_err_e;
endpackage

// File: rtl/frx_idle_timer.sv
module frx_idle_timer #(
   parameter int TO_CYC = 1088
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic rx_valid,
   output logic expire
);
   localparam int CW = $clog2(TO_CYC + 1);

   logic [CW-1:0] cnt_q;

   assign expire = armed && !rx_valid && (cnt_q == CW'(TO_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!armed || rx_valid || expire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/frx_parser.sv
module frx_parser
   import frx_pkg::*;
#(
   parameter logic [7:0] SOF_BYTE  = 8'hA5,
   parameter int         REC_BYTES = 3,
   parameter int         MAX_LEN   = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [7:0]                 rx_byte,
   input  logic                       rx_valid,
   input  logic [7:0]                 node_id,
   input  logic                       expire,
   output logic                       busy,
   output logic                       frame_ok,
   output logic                       frame_err,
   output logic [1:0]                 err_code,
   output logic                       buf_wr,
   output logic [(REC_BYTES-1)*8-1:0] buf_payload,
   output logic                       commit,
   output logic                       discard
);
   localparam int PAY_W  = (REC_BYTES - 1) * 8;
   localparam int FULL_W = REC_BYTES * 8;
   localparam int PW     = $clog2(REC_BYTES);

   frx_state_e       state_q;
   logic [7:0]       remain_q;
   logic [7:0]       sum_q;
   logic [7:0]       sum_next;
   logic [PW-1:0]    pos_q;
   logic [PAY_W-1:0] sr_q;
   logic [PAY_W-1:0] sr_d;
   logic [FULL_W-1:0] full_rec;
   logic             len_bad;
   logic             rec_done;
   logic             chk_seen;
   logic             chk_good;
   logic             len_fail;
   logic             ok_q;
   logic             err_q;
   logic [1:0]       code_q;

   // Record assembly: the shift register keeps every byte of the record but the last.
   generate
      if (REC_BYTES == 2) begin : g_sr_one
         assign sr_d = rx_byte;
      end else begin : g_sr_many
         assign sr_d = {sr_q[PAY_W-9:0], rx_byte};
      end
   endgenerate

   assign full_rec    = {sr_q, rx_byte};
   assign buf_payload = full_rec[PAY_W-1:0];
   assign sum_next    = sum_q + rx_byte;

   assign len_bad  = (int'(rx_byte) > MAX_LEN) || ((int'(rx_byte) % REC_BYTES) != 0);
   assign len_fail = (state_q == ST_LEN) && rx_valid && len_bad;
   assign rec_done = (state_q == ST_DATA) && rx_valid && (pos_q == PW'(REC_BYTES - 1));
   assign buf_wr   = rec_done && (full_rec[FULL_W-1 -: 8] == node_id);
   assign chk_seen = (state_q == ST_CHK) && rx_valid;
   assign chk_good = (sum_next == 8'h00);
   assign commit   = chk_seen && chk_good;
   assign discard  = (chk_seen && !chk_good) || expire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_HUNT;
         remain_q <= '0;
         sum_q    <= '0;
         pos_q    <= '0;
         sr_q     <= '0;
         ok_q     <= 1'b0;
         err_q    <= 1'b0;
         code_q   <= ERR_NONE;
      end else begin
         ok_q  <= commit;
         err_q <= discard || len_fail;
         if (expire) begin
            code_q  <= ERR_TIMEOUT;
            state_q <= ST_HUNT;
         end else if (rx_valid) begin
            unique case (state_q)
               ST_HUNT: begin
                  if (rx_byte == SOF_BYTE) begin
                     state_q <= ST_LEN;
                  end
               end
               ST_LEN: begin
                  if (len_bad) begin
                     code_q  <= ERR_LEN;
                     state_q <= ST_HUNT;
                  end else begin
                     sum_q    <= rx_byte;
                     remain_q <= rx_byte;
                     pos_q    <= '0;
                     state_q  <= (rx_byte == 8'h00) ? ST_CHK : ST_DATA;
                  end
               end
               ST_DATA: begin
                  sum_q    <= sum_next;
                  remain_q <= remain_q - 1'b1;
                  sr_q     <= sr_d;
                  pos_q    <= rec_done ? '0 : pos_q + 1'b1;
                  if (remain_q == 8'd1) begin
                     state_q <= ST_CHK;
                  end
               end
               ST_CHK: begin
                  if (!chk_good) begin
                     code_q <= ERR_SUM;
                  end
                  state_q <= ST_HUNT;
               end
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end

   assign busy      = (state_q != ST_HUNT);
   assign frame_ok  = ok_q;
   assign frame_err = err_q;
   assign err_code  = code_q;
endmodule

// File: rtl/frx_rec_buf.sv
module frx_rec_buf #(
   parameter int PAY_W = 16,
   parameter int DEPTH = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [PAY_W-1:0] wr_data,
   input  logic             commit,
   input  logic             discard,
   output logic             rd_valid,
   output logic [PAY_W-1:0] rd_data
);
   localparam int AW = $clog2(DEPTH);
   localparam int IW = $clog2(DEPTH + 1);

   logic [PAY_W-1:0] slot_arr [DEPTH];
   logic [IW-1:0]    wr_cnt_q;
   logic [IW-1:0]    drain_n_q;
   logic [AW-1:0]    rd_idx_q;
   logic             draining_q;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [PAY_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr && (wr_cnt_q == IW'(i))) begin
               q <= wr_data;
            end
         end
         assign slot_arr[i] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_cnt_q <= '0;
      end else if (commit || discard) begin
         wr_cnt_q <= '0;
      end else if (wr && (wr_cnt_q != IW'(DEPTH))) begin
         wr_cnt_q <= wr_cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         draining_q <= 1'b0;
         drain_n_q  <= '0;
         rd_idx_q   <= '0;
      end else if (commit) begin
         draining_q <= (wr_cnt_q != '0);
         drain_n_q  <= wr_cnt_q;
         rd_idx_q   <= '0;
      end else if (draining_q) begin
         if (IW'(rd_idx_q) == drain_n_q - 1'b1) begin
            draining_q <= 1'b0;
         end else begin
            rd_idx_q <= rd_idx_q + 1'b1;
         end
      end
   end

   assign rd_valid = draining_q;
   assign rd_data  = slot_arr[rd_idx_q];
endmodule

// File: rtl/frame_rx_top.sv
module frame_rx_top
   import frx_pkg::*;
#(
   parameter logic [7:0] SOF_BYTE     = 8'hA5,
   parameter int         REC_BYTES    = 3,
   parameter int         MAX_LEN      = 64,
   parameter int         CLKS_PER_BIT = 34,
   parameter int         TIMEOUT_BITS = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [7:0]                 rx_byte,
   input  logic                       rx_valid,
   input  logic [7:0]                 node_id,
   output logic                       busy,
   output logic                       frame_ok,
   output logic                       frame_err,
   output logic [1:0]                 err_code,
   output logic                       rec_valid,
   output logic [(REC_BYTES-1)*8-1:0] rec_payload
);
   localparam int PAY_W    = (REC_BYTES - 1) * 8;
   localparam int MAX_RECS = MAX_LEN / REC_BYTES;
   localparam int TO_CYC   = TIMEOUT_BITS * CLKS_PER_BIT;

   generate
      if (REC_BYTES < 2) begin : g_bad_rec
         $error("frame_rx_top: a record needs a module number and a payload byte");
      end
      if (MAX_LEN > 255 || MAX_LEN < 2 * REC_BYTES) begin : g_bad_len
         $error("frame_rx_top: MAX_LEN must fit the length byte and hold two records");
      end
      if (TO_CYC < 2) begin : g_bad_to
         $error("frame_rx_top: timeout window too short");
      end
   endgenerate

   logic             expire;
   logic             buf_wr;
   logic [PAY_W-1:0] buf_payload;
   logic             commit;
   logic             discard;

   frx_idle_timer #(
      .TO_CYC (TO_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (busy),
      .rx_valid (rx_valid),
      .expire   (expire)
   );

   frx_parser #(
      .SOF_BYTE  (SOF_BYTE),
      .REC_BYTES (REC_BYTES),
      .MAX_LEN   (MAX_LEN)
   ) u_parser (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_byte     (rx_byte),
      .rx_valid    (rx_valid),
      .node_id     (node_id),
      .expire      (expire),
      .busy        (busy),
      .frame_ok    (frame_ok),
      .frame_err   (frame_err),
      .err_code    (err_code),
      .buf_wr      (buf_wr),
      .buf_payload (buf_payload),
      .commit      (commit),
      .discard     (discard)
   );

   frx_rec_buf #(
      .PAY_W (PAY_W),
      .DEPTH (MAX_RECS)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (buf_wr),
      .wr_data  (buf_payload),
      .commit   (commit),
      .discard  (discard),
      .rd_valid (rec_valid),
      .rd_data  (rec_payload)
   );
endmodule

// File: rtl/frx_chk.sv
module frx_chk #(
   parameter int TO_CYC = 1088
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic       busy,
   input logic       frame_ok,
   input logic       frame_err,
   input logic [1:0] err_code,
   input logic       rec_valid,
   input logic       buf_wr
);
   localparam int CW = $clog2(TO_CYC + 2);

   logic [CW-1:0] quiet_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quiet_q <= '0;
      end else if (busy && !rx_valid) begin
         quiet_q <= quiet_q + 1'b1;
      end else begin
         quiet_q <= '0;
      end
   end

   // R11
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_ok && frame_err));

   // R11
   ok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> !frame_ok);

   // R11
   close_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (frame_ok || frame_err));

   // R6
   deliver_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec_valid) |-> frame_ok);

   // R4
   err_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> (err_code != 2'd0));

   // R8
   quiet_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (quiet_q < CW'(TO_CYC)));

   // R6
   no_fill_during_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_wr && rec_valid));
endmodule

bind frame_rx_top frx_chk #(
   .TO_CYC (TO_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .busy      (busy),
   .frame_ok  (frame_ok),
   .frame_err (frame_err),
   .err_code  (err_code),
   .rec_valid (rec_valid),
   .buf_wr    (buf_wr)
);

// File: tb/frame_rx_top_tb.sv
module frame_rx_top_tb;
   localparam logic [7:0] SOF    = 8'hA5;
   localparam logic [7:0] NODE   = 8'h05;
   localparam int         TO_CYC = 32 * 34;
   localparam int         GAP    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_valid = 1'b0;
   logic [7:0]  node_id = NODE;
   logic        busy, frame_ok, frame_err, rec_valid;
   logic [1:0]  err_code;
   logic [15:0] rec_payload;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   logic [15:0] exp_q [$];
   int          stat_q [$];
   logic [7:0]  fq [$];

   always #4 clk = ~clk;

   frame_rx_top u_dut (
      .clk (clk), .rst_n (rst_n), .rx_byte (rx_byte), .rx_valid (rx_valid),
      .node_id (node_id), .busy (busy), .frame_ok (frame_ok), .frame_err (frame_err),
      .err_code (err_code), .rec_valid (rec_valid), .rec_payload (rec_payload)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard as records and frame outcomes appear.
   always @(negedge clk) begin
      if (mon_on) begin
         if (rec_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected record", {16'h0, rec_payload}, 32'h0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               check(rec_payload == e, "R6 record payload/order", {16'h0, rec_payload}, {16'h0, e});
            end
         end
         if (frame_ok || frame_err) begin
            int got;
            got = frame_ok ? 0 : int'(err_code);
            if (stat_q.size() == 0) begin
               check(1'b0, "R2 unexpected outcome", got, 32'hFF);
            end else begin
               int e;
               e = stat_q.pop_front();
               check(got == e, "R5 outcome/err_code", got, e);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         check(1'b0, "watchdog", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic send_byte(input logic [7:0] b, input int gap);
      @(negedge clk);
      rx_byte  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic add_rec(input logic [7:0] id, input logic [15:0] pay);
      fq.push_back(id);
      fq.push_back(pay[15:8]);
      fq.push_back(pay[7:0]);
   endtask

   // Driver: computes expectations from the frame contents, then sends it.
   task automatic send_frame(input bit corrupt, input string req);
      logic [7:0] sum;
      logic [7:0] chk;
      int nmatch;
      nmatch = 0;
      sum = 8'(fq.size());
      foreach (fq[i]) sum = sum + fq[i];
      chk = 8'(8'h00 - sum) ^ (corrupt ? 8'h01 : 8'h00);
      if (!corrupt) begin
         for (int r = 0; r + 2 < fq.size(); r += 3) begin
            if (fq[r] == NODE) begin
               exp_q.push_back({fq[r+1], fq[r+2]});
               nmatch++;
            end
         end
         stat_q.push_back(0);
      end else begin
         stat_q.push_back(1);
      end
      send_byte(SOF, 0);
      check(busy == 1'b1, "R3 busy after start marker", busy, 1);
      repeat (GAP) @(negedge clk);
      send_byte(8'(fq.size()), GAP);
      foreach (fq[i]) send_byte(fq[i], GAP);
      send_byte(chk, 0);
      check(frame_ok == !corrupt, {req, " frame_ok timing"}, frame_ok, !corrupt);
      check(rec_valid == (nmatch > 0), "R6 first record with frame_ok", rec_valid, nmatch > 0);
      repeat (30) @(negedge clk);
      fq.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !frame_ok && !frame_err && !rec_valid, "R1 reset state",
            {busy, frame_ok, frame_err, rec_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !frame_ok && !frame_err && !rec_valid, "R1 after reset release",
            {busy, frame_ok, frame_err, rec_valid}, 0);
      mon_on = 1'b1;

      // R2: junk while hunting
      send_byte(8'h00, 0);
      check(busy == 1'b0, "R2 junk ignored", busy, 0);
      send_byte(8'h7E, 0);
      check(busy == 1'b0, "R2 junk ignored", busy, 0);
      send_byte(8'hFF, GAP);
      check(busy == 1'b0, "R2 junk ignored", busy, 0);

      // R5 R6 R7: mixed records
      add_rec(NODE, 16'h1234);
      add_rec(8'h09, 16'hDEAD);
      add_rec(NODE, 16'hBEEF);
      send_frame(1'b0, "R5");

      // R5 R7: bad checksum drops staged records
      add_rec(NODE, 16'h5555);
      send_frame(1'b1, "R5 bad sum");

      // R4: length over limit, then length not a record multiple
      stat_q.push_back(2);
      send_byte(SOF, GAP);
      send_byte(8'd66, 0);
      check(busy == 1'b0, "R4 oversize length closes frame", busy, 0);
      repeat (GAP) @(negedge clk);
      stat_q.push_back(2);
      send_byte(SOF, GAP);
      send_byte(8'd4, 0);
      check(busy == 1'b0, "R4 odd length closes frame", busy, 0);
      repeat (GAP) @(negedge clk);

      // R9: empty frame
      send_frame(1'b0, "R9");

      // R10: start marker value inside the frame
      add_rec(NODE, {SOF, SOF});
      add_rec(SOF, 16'h0101);
      send_frame(1'b0, "R10");

      // R8: timeout after a full matching record
      begin
         int w;
         stat_q.push_back(3);
         send_byte(SOF, GAP);
         send_byte(8'd6, GAP);
         send_byte(NODE, GAP);
         send_byte(8'h77, GAP);
         send_byte(8'h88, 0);
         w = 0;
         while (!frame_err && w < TO_CYC + 10) begin
            @(negedge clk);
            w++;
         end
         check(w == TO_CYC, "R8 timeout cycle", w, TO_CYC);
         check(busy == 1'b0, "R8 busy drops", busy, 0);
         check(err_code == 2'd3, "R8 err_code", err_code, 3);
         repeat (GAP) @(negedge clk);
      end

      // R6: largest legal frame, all records for this node
      for (int k = 0; k < 21; k++) add_rec(NODE, 16'(16'h0A00 + k));
      send_frame(1'b0, "R6 max length");

      // R7: frame entirely for other modules
      add_rec(8'h06, 16'h4242);
      add_rec(8'h04, 16'h4343);
      send_frame(1'b0, "R7");

      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R6 all records delivered", exp_q.size(), 0);
      check(stat_q.size() == 0, "R5 all outcomes seen", stat_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule